// File: doc/BRIEF.md
# Three-Lane 7:1 Serial-to-Parallel Deserializer

This block rebuilds a 21-bit parallel word from three serial data lanes. Each lane delivers seven bits during every period of a forwarded frame clock. The block runs on a bit clock that is seven times the frame rate, so each bit lasts one bit-clock cycle. It samples the frame clock as an ordinary input in that domain. A rising edge of the frame clock marks bit 0 of a new word on every lane. Completed words pass through a two-word delay line and are then presented on `word_o`. A regenerated word strobe `wclk_o` goes high in the middle of each presented word.

Three digital flags describe the link. `lane_ok_i` marks each data lane as present. `fclk_ok_i` marks the frame clock as present. The active-low `pdn_n_i` puts the block into power-down. These flags select a fail-safe policy:
- A dead lane is read as all ones.
- A dead frame clock freezes the output word and parks the strobe low.
- Power-down drives the word and the strobe low.

After any of these faults, only words captured in full after recovery ever reach the output. Frame rates of 15 to 75 MHz correspond to bit clocks of up to 525 MHz. The analog receivers and the clock multiplier lie outside this block.

Top module: `tri_lane_deser`

## Requirements
- R1: Lane k supplies output bits 7k to 7k+6. The lane's bit 0 lands at index 7k and its bit 6 at index 7k+6, giving a 21-bit word.
- R2: Bit 0 of a word is the lane value sampled in the first bit-clock cycle where `frame_clk_i` is high after being low. The next six cycles carry bits 1 to 6.
- R3: At the clock edge where `word_o` takes a new value, `wclk_o` goes low. It stays low for three bit cycles and then goes high. `word_o` never changes at a rising edge of `wclk_o`.
- R4: A word whose bit 6 is sampled at one edge appears on `word_o` after the edge that samples bit 6 of the second following word. With a steady frame clock this is two frame periods.
- R5: While a lane's `lane_ok_i` bit is 0 and the frame clock is present, that lane is sampled as 1. Its seven output bits therefore read high once the word reaches the output.
- R6: While `fclk_ok_i` is 0, `word_o` keeps its value and `wclk_o` is low. A word in progress, including one whose bit 6 falls in such a cycle, is dropped.
- R7: While `pdn_n_i` is 0, `word_o` is all zeros and `wclk_o` is 0 in the same cycle.
- R8: After power-down is released or the frame clock returns, `word_o` stays unchanged until a word captured entirely after the recovery has passed through the R4 delay. Words held before the fault are discarded.
- R9: A new frame-clock rising edge that arrives before bit 6 drops the partial word and starts a new word at bit 0.
- R10: A synchronous active-high `rst` clears alignment and delay state, drives `word_o` to zero and holds `wclk_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven times the frame rate |
| rst | input | 1 | Synchronous active-high reset |
| frame_clk_i | input | 1 | Forwarded frame clock, sampled in the bit-clock domain |
| lanes_i | input | 3 | Serial data lanes, one bit per bit-clock cycle |
| lane_ok_i | input | 3 | Per-lane presence flag; 0 marks a dead lane |
| fclk_ok_i | input | 1 | Frame clock presence flag; 0 marks a dead clock |
| pdn_n_i | input | 1 | Active-low power-down |
| word_o | output | 21 | Parallel output word |
| wclk_o | output | 1 | Regenerated word strobe; its rising edge marks valid data |

## Verification
The frame clock can be lost in the same bit cycle in which bit 6 of a word is sampled, so word completion and the clock-loss flush meet in one edge. The bench provokes this by dropping `fclk_ok_i` exactly in the seventh bit slot of a word. The behavioural reference model in the bench then expects the word to be discarded, the previous output to be held, and only post-recovery words to appear later. Power-down likewise lands on an idle cycle next to live delay-line contents, and the bench judges it by the immediate zero output and the later absence of any pre-fault word.

// File: rtl/tld_pkg.sv
package tld_pkg;

  // Fail-safe substitution for a lane marked absent: the bit reads as one.
  function automatic logic fs_bit(input logic raw, input logic present);
    return present ? raw : 1'b1;
  endfunction

  // Strobe level for a given phase since the last word update.
  function automatic logic strobe_level(input int unsigned phase, input int unsigned bits);
    return phase >= (bits / 2);
  endfunction

  // Counter width for an index 0..n-1.
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tld_align.sv
module tld_align
  import tld_pkg::*;
#(
  parameter int BITS = 7,
  parameter int CW   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fclk_i,
  input  logic          active_i,
  output logic          start_o,
  output logic          take_o,
  output logic          done_o,
  output logic [CW-1:0] idx_o
);
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic          fclk_d;
  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          rise;

  assign rise    = fclk_i & ~fclk_d;
  assign start_o = active_i & rise;
  assign take_o  = active_i & (start_o | busy_q);
  assign idx_o   = start_o ? '0 : cnt_q;
  assign done_o  = take_o & (idx_o == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      fclk_d <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      fclk_d <= fclk_i;
      if (!active_i) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (take_o) begin
        if (idx_o == LAST) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          busy_q <= 1'b1;
          cnt_q  <= idx_o + CW'(1);
        end
      end
    end
  end

  // R2
  start_step_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |=> (cnt_q == CW'(1)) && busy_q);

  // R9
  restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start_o) |=> (cnt_q == CW'(1)));

endmodule

// File: rtl/tld_lane.sv
module tld_lane
  import tld_pkg::*;
#(
  parameter int BITS = 7,
  parameter int CW   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take_i,
  input  logic [CW-1:0]   idx_i,
  input  logic            serial_i,
  input  logic            present_i,
  output logic [BITS-1:0] word_o
);
  logic [BITS-1:0] sh_q;
  logic            bit_s;

  assign bit_s = fs_bit(serial_i, present_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
    end else if (take_i) begin
      for (int j = 0; j < BITS; j++) begin
        if (idx_i == CW'(j)) sh_q[j] <= bit_s;
      end
    end
  end

  // Word including the bit sampled in this cycle, used on completion.
  always_comb begin
    for (int j = 0; j < BITS; j++) begin
      word_o[j] = (take_i && (idx_i == CW'(j))) ? bit_s : sh_q[j];
    end
  end

endmodule

// File: rtl/tld_pipe.sv
module tld_pipe
  import tld_pkg::*;
#(
  parameter int W     = 21,
  parameter int BITS  = 7,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pdn_n_i,
  input  logic         fok_i,
  input  logic         done_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] word_o,
  output logic         wclk_o
);
  localparam int          OW    = idx_width(BITS);
  localparam logic [OW-1:0] LASTP = OW'(BITS - 1);

  logic [W-1:0]     st_q [DEPTH];
  logic [DEPTH-1:0] v_q;
  logic [W-1:0]     out_q;
  logic             ovalid_q;
  logic [OW-1:0]    ocnt_q;
  logic             flush;
  logic             upd;

  assign flush = ~pdn_n_i | ~fok_i;
  assign upd   = done_i & v_q[DEPTH-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q      <= '0;
      out_q    <= '0;
      ovalid_q <= 1'b0;
      ocnt_q   <= '0;
      for (int i = 0; i < DEPTH; i++) st_q[i] <= '0;
    end else begin
      if (flush) begin
        v_q <= '0;
      end else if (done_i) begin
        st_q[0] <= word_i;
        v_q[0]  <= 1'b1;
        for (int i = 1; i < DEPTH; i++) begin
          st_q[i] <= st_q[i-1];
          v_q[i]  <= v_q[i-1];
        end
      end
      if (!pdn_n_i) begin
        out_q    <= '0;
        ovalid_q <= 1'b0;
      end else if (upd) begin
        out_q    <= st_q[DEPTH-1];
        ovalid_q <= 1'b1;
      end
      if (upd)                  ocnt_q <= '0;
      else if (ocnt_q != LASTP) ocnt_q <= ocnt_q + OW'(1);
    end
  end

  assign word_o = pdn_n_i ? out_q : '0;
  assign wclk_o = pdn_n_i & fok_i & ovalid_q & strobe_level(int'(ocnt_q), BITS);

  // R7
  pdn_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !pdn_n_i |=> (out_q == '0) && !ovalid_q);

  // R6
  hold_dead_chk: assert property (@(posedge clk) disable iff (rst)
    (pdn_n_i && !fok_i) |=> $stable(out_q));

  // R3
  strobe_stable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wclk_o) |-> $stable(out_q));

  // R4
  first_word_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovalid_q) |-> $past(done_i));

endmodule

// File: rtl/tri_lane_deser.sv
module tri_lane_deser
  import tld_pkg::*;
#(
  parameter int LANES = 3,
  parameter int BITS  = 7,
  parameter int LAT   = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frame_clk_i,
  input  logic [LANES-1:0]      lanes_i,
  input  logic [LANES-1:0]      lane_ok_i,
  input  logic                  fclk_ok_i,
  input  logic                  pdn_n_i,
  output logic [LANES*BITS-1:0] word_o,
  output logic                  wclk_o
);
  localparam int W  = LANES * BITS;
  localparam int CW = idx_width(BITS);

  logic          active;
  logic          start_s;
  logic          take_s;
  logic          done_s;
  logic [CW-1:0] idx_s;
  logic [W-1:0]  cap_word;

  assign active = pdn_n_i & fclk_ok_i;

  tld_align #(.BITS(BITS), .CW(CW)) u_align (
    .clk      (clk),
    .rst      (rst),
    .fclk_i   (frame_clk_i),
    .active_i (active),
    .start_o  (start_s),
    .take_o   (take_s),
    .done_o   (done_s),
    .idx_o    (idx_s)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    tld_lane #(.BITS(BITS), .CW(CW)) u_lane (
      .clk       (clk),
      .rst       (rst),
      .take_i    (take_s),
      .idx_i     (idx_s),
      .serial_i  (lanes_i[k]),
      .present_i (lane_ok_i[k]),
      .word_o    (cap_word[k*BITS +: BITS])
    );
  end

  tld_pipe #(.W(W), .BITS(BITS), .DEPTH(LAT)) u_pipe (
    .clk     (clk),
    .rst     (rst),
    .pdn_n_i (pdn_n_i),
    .fok_i   (fclk_ok_i),
    .done_i  (done_s),
    .word_i  (cap_word),
    .word_o  (word_o),
    .wclk_o  (wclk_o)
  );

  // R6
  no_capture_dead_chk: assert property (@(posedge clk) disable iff (rst)
    !fclk_ok_i |-> !done_s && !start_s);

endmodule

// File: tb/tri_lane_deser_tb_top.sv
module tri_lane_deser_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_clk_i = 1'b0;
  logic [2:0]  lanes_i = '0;
  logic [2:0]  lane_ok_i = 3'b111;
  logic        fclk_ok_i = 1'b1;
  logic        pdn_n_i = 1'b1;
  logic [20:0] word_o;
  logic        wclk_o;

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  string cur_req = "R10";

  always #4 clk = ~clk;

  tri_lane_deser dut_i (
    .clk(clk), .rst(rst), .frame_clk_i(frame_clk_i), .lanes_i(lanes_i),
    .lane_ok_i(lane_ok_i), .fclk_ok_i(fclk_ok_i), .pdn_n_i(pdn_n_i),
    .word_o(word_o), .wclk_o(wclk_o)
  );

  // Behavioural reference model
  logic [20:0] m_q[$];
  logic [20:0] m_cur = '0;
  logic [20:0] m_out = '0;
  bit          m_valid = 0;
  bit          m_inword = 0;
  bit          m_fprev = 0;
  int          m_pos = 0;
  int          m_since = 0;

  always @(posedge clk) begin
    bit upd;
    upd = 0;
    if (rst) begin
      m_q.delete(); m_out = '0; m_valid = 0; m_inword = 0; m_fprev = 0; m_since = 0;
    end else begin
      bit rise;
      rise = frame_clk_i && !m_fprev;
      m_fprev = frame_clk_i;
      if (!pdn_n_i) begin
        m_q.delete(); m_inword = 0; m_out = '0; m_valid = 0;
      end else if (!fclk_ok_i) begin
        m_q.delete(); m_inword = 0;
      end else begin
        if (rise) begin m_pos = 0; m_inword = 1; end
        if (m_inword) begin
          for (int k = 0; k < 3; k++)
            m_cur[7*k + m_pos] = lane_ok_i[k] ? lanes_i[k] : 1'b1;
          if (m_pos == 6) begin
            m_q.push_back(m_cur);
            m_inword = 0;
            if (m_q.size() > 2) begin
              m_out = m_q.pop_front(); m_valid = 1; upd = 1; m_since = 0;
            end
          end else m_pos++;
        end
      end
      if (!upd && m_since < 6) m_since++;
    end
  end

  // Compare with the model on every clock
  always @(posedge clk) begin
    #2;
    if (!rst && !finished) begin
      logic [20:0] ew;
      logic        es;
      ew = pdn_n_i ? m_out : '0;
      es = pdn_n_i && fclk_ok_i && m_valid && (m_since >= 3);
      checks++;
      if (word_o !== ew) begin
        errors++;
        $display("FAIL %s model word: got %h exp %h", cur_req, word_o, ew);
      end
      checks++;
      if (wclk_o !== es) begin
        errors++;
        $display("FAIL %s model strobe: got %b exp %b", cur_req, wclk_o, es);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk_word(input string req, input logic [20:0] exp);
    checks++;
    if (word_o !== exp) begin
      errors++;
      $display("FAIL %s word: got %h exp %h", req, word_o, exp);
    end
  endtask

  task automatic chk_strobe(input string req, input logic exp);
    checks++;
    if (wclk_o !== exp) begin
      errors++;
      $display("FAIL %s strobe: got %b exp %b", req, wclk_o, exp);
    end
  endtask

  // Seven bit slots; frame clock high in slots 0..3. kill drops the clock flag in slot 6.
  task automatic send_word(input logic [20:0] w, input bit kill = 0, input int slots = 7);
    for (int i = 0; i < slots; i++) begin
      @(negedge clk);
      frame_clk_i = (i < 4);
      for (int k = 0; k < 3; k++) lanes_i[k] = w[7*k + i];
      if (kill && i == 6) fclk_ok_i = 1'b0;
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [20:0] wa, wb, wc, wd, we, wf, wg, wh, wi, wj, wk, wl, wm, wn, wo;
    wa = 21'h004001; wb = 21'h12345A; wc = 21'h0F0F0F;
    wd = 21'h1A2B3C; we = 21'h055555; wf = 21'h0AAAAA;
    wg = 21'h1C0E07; wh = 21'h03F00F; wi = 21'h15A5A5;
    wj = 21'h000F81; wk = 21'h1FFFFE; wl = 21'h0C3C3C;
    wm = 21'h013579; wn = 21'h1ECA86; wo = 21'h0ABCDE;

    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R10: reset state
    chk_word("R10", '0);
    chk_strobe("R10", 1'b0);

    // R1 R2 R4: basic capture and delay
    cur_req = "R4";
    send_word(wa); send_word(wb); send_word(wc);
    chk_word("R4 before delay elapsed", '0);
    tick();
    chk_word("R1 lane mapping / R4 delay", wa);
    // R3: strobe low for three cycles, then high
    cur_req = "R3";
    chk_strobe("R3 update cycle", 1'b0);
    tick(); chk_strobe("R3 phase1", 1'b0);
    tick(); chk_strobe("R3 phase2", 1'b0);
    tick(); chk_strobe("R3 phase3", 1'b1);
    chk_word("R3 word stable at strobe rise", wa);

    // R5: lane 1 dead, clock alive
    cur_req = "R5";
    @(negedge clk); lane_ok_i = 3'b101;
    send_word(wd); send_word(we); send_word(wf);
    tick();
    chk_word("R5 dead lane reads high", wd | (21'h7F << 7));
    @(negedge clk); lane_ok_i = 3'b111;

    // R9: partial word restarted by an early rising edge
    cur_req = "R9";
    send_word(21'h1FFFFF, 0, 5);
    send_word(wg); send_word(wh); send_word(wi);
    tick();
    chk_word("R9 restart discards partial", wg);

    // R6: clock lost in the same cycle as bit 6
    cur_req = "R6";
    send_word(21'h155555, 1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      frame_clk_i = i[1];
      lanes_i = 3'(i);
    end
    @(negedge clk); frame_clk_i = 1'b0;
    #1;
    chk_word("R6 held on clock loss", wg);
    chk_strobe("R6 strobe low on clock loss", 1'b0);

    // R8: clock returns
    cur_req = "R8";
    @(negedge clk); fclk_ok_i = 1'b1;
    send_word(wj); send_word(wk);
    tick();
    chk_word("R8 no stale word after clock return", wg);
    send_word(wl);
    tick();
    chk_word("R8 first post-recovery word", wj);

    // R7: power-down
    cur_req = "R7";
    @(negedge clk); pdn_n_i = 1'b0;
    #1;
    chk_word("R7 immediate zero", '0);
    chk_strobe("R7 strobe low", 1'b0);
    repeat (5) tick();
    chk_word("R7 zero during power-down", '0);
    @(negedge clk); pdn_n_i = 1'b1;
    cur_req = "R8";
    send_word(wm); send_word(wn);
    tick();
    chk_word("R8 zero until delayed word", '0);
    chk_strobe("R8 strobe low until delayed word", 1'b0);
    send_word(wo);
    tick();
    chk_word("R8 R4 word after power-down", wm);

    repeat (10) tick();
    finished = 1;
    summary();
    $finish;
  end

endmodule